// File: doc/BRIEF.md
# SD Command Issue Sequencer

This block sits between software-visible registers and the card-facing command engine of an SD host. Software loads an argument word and a block-geometry word, then writes a command word; that write launches the command toward the line engine as a one-cycle start pulse carrying the command index, argument and expected response format. The block then waits for the card's reply. The reply arrives already de-serialised, with its CRC byte removed, together with CRC and index error flags.

While a command is outstanding, the block holds a command-busy flag that software polls before issuing the next one. A second flag covers commands that occupy the data lines: those that carry data, and those whose reply is followed by a busy period. The reply is stored in up to four 32-bit words. Completion, timeout, CRC error and index error are reported as single-cycle event pulses. Three self-clearing control bits reset the command side, the data side, or the whole block.

Top module: `sd_cmd_sequencer`

## Requirements
- R1: Registers sit at word addresses 0 argument, 1 block geometry (count in bits 31:16, size in bits 15:0), 2 command, 3 status, 4 control, 5 to 8 reply words 0 to 3. A write to address 2 while status bit 0 is clear launches a command. In the next cycle `go` pulses with `go_index` equal to command bits 29:24, `go_rtype` equal to bits 17:16, and `go_arg` equal to the stored argument. The argument and geometry registers read back what was written.
- R2: Reply format codes in command bits 17:16 are 0 none, 1 long (136-bit), 2 short (48-bit) and 3 short with busy. A code-0 launch pulses `ev_done` in the cycle after the write and never sets status bit 0. `ev_done` and `ev_timeout` never pulse together.
- R3: Status bit 0 (command busy) is set from a launch with a nonzero code until a reply is accepted or a timeout occurs. A reply presented while no command is outstanding is ignored, with no event and no change to the reply words.
- R4: A write to the command register while status bit 0 is set is ignored. It produces no `go` pulse, and the command register keeps its previous value.
- R5: A long reply stores reply bits 31:0, 63:32 and 95:64 in words 0, 1 and 2, and stores bits 119:96 zero-extended in word 3.
- R6: A short reply (code 2 or 3) stores reply bits 31:0 in word 0 and leaves words 1 to 3 unchanged.
- R7: With the reply, `ev_crc` pulses only if command bit 19 (CRC check) is set and the CRC error flag is raised. `ev_index` pulses only if command bit 20 (index check) is set and the index error flag is raised. `ev_done` pulses with every accepted reply.
- R8: Control bits 15:0 hold the timeout limit L (default 64). If no reply arrives by the L-th cycle edge after the launch edge, `ev_timeout` pulses at that edge and status bit 0 clears. A reply on that same edge takes precedence over the timeout.
- R9: Status bit 1 (data busy) is set by a launch with command bit 21 (data present) set or with code 3. It is cleared only by a `dat_done` pulse or by a reset.
- R10: Control bits 24 (all), 25 (command side) and 26 (data side) read back set for one cycle after the write and then clear themselves as the reset takes effect. The command-side reset clears status bit 0 and the timeout count. The data-side reset clears status bit 1. The full reset also clears the argument, geometry, command and reply registers and restores the default limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| go | output | 1 | Command start pulse to the line engine |
| go_index | output | 6 | Command index of the launched command |
| go_arg | output | 32 | Argument of the launched command |
| go_rtype | output | 2 | Expected reply format |
| rsp_valid | input | 1 | Reply present this cycle |
| rsp_bits | input | 120 | Reply content with the CRC byte removed |
| rsp_crc_err | input | 1 | Reply CRC mismatch |
| rsp_idx_err | input | 1 | Reply index mismatch |
| dat_done | input | 1 | Data transfer or busy period finished |
| ev_done | output | 1 | Command complete pulse |
| ev_timeout | output | 1 | Reply timeout pulse |
| ev_crc | output | 1 | Reply CRC error pulse |
| ev_index | output | 1 | Reply index error pulse |

## Verification
The bench targets the edge where a timeout and a reply coincide. A design that let the timeout win would report a timeout and drop a valid reply. A command write issued while the previous command is pending must leave no trace: a design that does not gate the write would pulse `go` a second time or overwrite the stored command. The bench also checks that a short reply leaves the upper reply words untouched, that error flags are suppressed when their check enable is off, and that each partial reset clears only its own busy flag. A design that merged the two flags, or wired the resets to the wrong side, would show the wrong status bits after the reset.

// File: rtl/sd_cmd_sequencer.sv
module sd_cmd_sequencer #(
  parameter int TMO_W       = 16,
  parameter int TMO_DEFAULT = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [3:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  output logic         go,
  output logic [5:0]   go_index,
  output logic [31:0]  go_arg,
  output logic [1:0]   go_rtype,
  input  logic         rsp_valid,
  input  logic [119:0] rsp_bits,
  input  logic         rsp_crc_err,
  input  logic         rsp_idx_err,
  input  logic         dat_done,
  output logic         ev_done,
  output logic         ev_timeout,
  output logic         ev_crc,
  output logic         ev_index
);
  localparam logic [3:0] A_ARG = 4'd0, A_BLK = 4'd1, A_CMD = 4'd2, A_STAT = 4'd3, A_CTRL = 4'd4;
  localparam logic [3:0] A_RSP0 = 4'd5;
  localparam logic [TMO_W-1:0] LIM_RST = TMO_W'(TMO_DEFAULT);

  logic [31:0]      arg_q, blk_q, cmd_q;
  logic [31:0]      rsp_q [4];
  logic [TMO_W-1:0] tmo_lim, tmo_cnt;
  logic             cmd_inh, dat_inh;
  logic [2:0]       rst_q;

  wire       wr_cmd  = reg_wr && reg_addr == A_CMD;
  wire       wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire       crs     = rst_q[0] | rst_q[1];
  wire       drs     = rst_q[0] | rst_q[2];
  wire [1:0] new_rt  = reg_wdata[17:16];
  wire       launch  = wr_cmd && !cmd_inh && !crs;
  wire       accept  = rsp_valid && cmd_inh && !crs;
  wire       tmo_hit = cmd_inh && !rsp_valid && !crs && tmo_cnt == TMO_W'(tmo_lim - 1'b1);

  always_comb begin
    reg_rdata = 32'h0;
    case (reg_addr)
      A_ARG:  reg_rdata = arg_q;
      A_BLK:  reg_rdata = blk_q;
      A_CMD:  reg_rdata = cmd_q;
      A_STAT: reg_rdata = {30'h0, dat_inh, cmd_inh};
      A_CTRL: reg_rdata = 32'(tmo_lim) | ({29'h0, rst_q} << 24);
      default:
        if (reg_addr >= A_RSP0 && reg_addr <= A_RSP0 + 4'd3)
          reg_rdata = rsp_q[2'(reg_addr - A_RSP0)];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q <= '0; blk_q <= '0; cmd_q <= '0;
      for (int i = 0; i < 4; i++) rsp_q[i] <= '0;
      tmo_lim <= LIM_RST; tmo_cnt <= '0;
      cmd_inh <= 1'b0; dat_inh <= 1'b0; rst_q <= '0;
      go <= 1'b0; go_index <= '0; go_arg <= '0; go_rtype <= '0;
      ev_done <= 1'b0; ev_timeout <= 1'b0; ev_crc <= 1'b0; ev_index <= 1'b0;
    end else begin
      go         <= launch;
      ev_done    <= (launch && new_rt == 2'd0) || accept;
      ev_timeout <= tmo_hit;
      ev_crc     <= accept && rsp_crc_err && cmd_q[19];
      ev_index   <= accept && rsp_idx_err && cmd_q[20];
      rst_q      <= wr_ctrl ? reg_wdata[26:24] : 3'b000;

      if (reg_wr && reg_addr == A_ARG) arg_q <= reg_wdata;
      if (reg_wr && reg_addr == A_BLK) blk_q <= reg_wdata;
      if (wr_ctrl) tmo_lim <= reg_wdata[TMO_W-1:0];

      if (dat_done) dat_inh <= 1'b0;

      if (launch) begin
        cmd_q    <= reg_wdata;
        go_index <= reg_wdata[29:24];
        go_arg   <= arg_q;
        go_rtype <= new_rt;
        cmd_inh  <= new_rt != 2'd0;
        tmo_cnt  <= '0;
        if (reg_wdata[21] || new_rt == 2'd3) dat_inh <= 1'b1;
      end else if (accept) begin
        cmd_inh  <= 1'b0;
        rsp_q[0] <= rsp_bits[31:0];
        if (cmd_q[17:16] == 2'd1) begin
          rsp_q[1] <= rsp_bits[63:32];
          rsp_q[2] <= rsp_bits[95:64];
          rsp_q[3] <= {8'h0, rsp_bits[119:96]};
        end
      end else if (tmo_hit) begin
        cmd_inh <= 1'b0;
      end else if (cmd_inh) begin
        tmo_cnt <= tmo_cnt + 1'b1;
      end

      if (crs) begin cmd_inh <= 1'b0; tmo_cnt <= '0; end
      if (drs) dat_inh <= 1'b0;
      if (rst_q[0]) begin
        arg_q <= '0; blk_q <= '0; cmd_q <= '0; tmo_lim <= LIM_RST;
        for (int i = 0; i < 4; i++) rsp_q[i] <= '0;
      end
    end
  end

  p_no_relaunch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && cmd_inh) |=> !go);
  p_done_xor_tmo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_done, ev_timeout}));
  p_none_no_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && go_rtype == 2'd0) |-> !cmd_inh);
  p_tmo_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |-> !cmd_inh);
  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_crc || ev_index) |-> ev_done);
  p_selfclear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q != 3'b000 && !wr_ctrl) |=> rst_q == 3'b000);
endmodule

// File: tb/sim_sd_cmd_sequencer.sv
module sim_sd_cmd_sequencer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic go; logic [5:0] go_index; logic [31:0] go_arg; logic [1:0] go_rtype;
  logic rsp_valid = 1'b0; logic [119:0] rsp_bits = '0;
  logic rsp_crc_err = 1'b0, rsp_idx_err = 1'b0, dat_done = 1'b0;
  logic ev_done, ev_timeout, ev_crc, ev_index;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sd_cmd_sequencer u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mkcmd(int idx, int rt, bit crc, bit ix, bit dp);
    return (32'(idx & 63) << 24) | (32'(crc) << 19) | (32'(ix) << 20) | (32'(dp) << 21) | (32'(rt & 3) << 16);
  endfunction

  function automatic logic [119:0] rnd120();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic reply(logic [119:0] b, bit ce, bit ie);
    @(negedge clk); rsp_valid = 1'b1; rsp_bits = b; rsp_crc_err = ce; rsp_idx_err = ie;
    @(negedge clk); rsp_valid = 1'b0; rsp_crc_err = 1'b0; rsp_idx_err = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, r1_keep;
    logic [119:0] b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd3, v); check("R3 reset status", v, 0);
    rd(4'd4, v); check("R8 reset limit", v, 64);

    wr(4'd4, 32'd8);
    wr(4'd0, 32'h12345678); wr(4'd1, {16'd3, 16'd512});
    rd(4'd0, v); check("R1 arg readback", v, 32'h12345678);
    rd(4'd1, v); check("R1 geometry readback", v, {16'd3, 16'd512});

    wr(4'd2, mkcmd(5, 0, 0, 0, 0));
    check("R1 go", go, 1); check("R1 index", go_index, 5);
    check("R1 arg", go_arg, 32'h12345678); check("R2 rtype none", go_rtype, 0);
    check("R2 immediate done", ev_done, 1);
    rd(4'd3, v); check("R2 no busy", v, 0);

    wr(4'd2, mkcmd(2, 1, 1, 0, 0));
    rd(4'd3, v); check("R3 busy set", v, 1);
    wr(4'd2, mkcmd(9, 2, 0, 0, 0));
    check("R4 no second go", go, 0);
    rd(4'd2, v); check("R4 command kept", v, mkcmd(2, 1, 1, 0, 0));
    b = 120'h112233_44556677_8899aabb_ccddeeff;
    reply(b, 0, 0);
    check("R7 done", ev_done, 1); check("R7 no crc", ev_crc, 0);
    rd(4'd5, v); check("R5 word0", v, 32'hccddeeff);
    rd(4'd6, v); check("R5 word1", v, 32'h8899aabb);
    rd(4'd7, v); check("R5 word2", v, 32'h44556677);
    rd(4'd8, v); check("R5 word3", v, 32'h00112233);
    rd(4'd3, v); check("R3 busy clear", v, 0);

    wr(4'd2, mkcmd(17, 2, 0, 1, 0));
    reply(120'hfeed_0000_0000_cafef00d, 1, 1);
    check("R7 crc masked", ev_crc, 0); check("R7 index reported", ev_index, 1);
    rd(4'd5, v); check("R6 word0", v, 32'hcafef00d);
    rd(4'd6, v); check("R6 word1 unchanged", v, 32'h8899aabb);

    wr(4'd2, mkcmd(13, 2, 1, 0, 0));
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      check("R8 no early timeout", ev_timeout, 0);
    end
    @(negedge clk);
    check("R8 timeout at limit", ev_timeout, 1);
    rd(4'd3, v); check("R8 busy freed", v, 0);
    reply(120'h5555, 0, 0);
    check("R3 stray reply no done", ev_done, 0);
    rd(4'd5, v); check("R3 stray reply ignored", v, 32'hcafef00d);

    wr(4'd2, mkcmd(7, 3, 0, 0, 0));
    rd(4'd3, v); check("R9 busy type sets both", v, 3);
    reply(120'h1, 0, 0);
    rd(4'd3, v); check("R9 data busy stays", v, 2);
    @(negedge clk); dat_done = 1'b1; @(negedge clk); dat_done = 1'b0;
    rd(4'd3, v); check("R9 dat_done clears", v, 0);

    wr(4'd2, mkcmd(18, 2, 0, 0, 1));
    rd(4'd3, v); check("R9 data present sets", v, 3);
    wr(4'd4, (32'd1 << 25) | 32'd8);
    rd(4'd4, v); check("R10 cmd reset visible", v, (32'd1 << 25) | 32'd8);
    @(negedge clk);
    rd(4'd4, v); check("R10 cmd reset self-clear", v, 32'd8);
    rd(4'd3, v); check("R10 cmd side only", v, 2);
    wr(4'd2, mkcmd(3, 2, 0, 0, 0));
    wr(4'd4, (32'd1 << 26) | 32'd8);
    @(negedge clk);
    rd(4'd3, v); check("R10 data side only", v, 1);
    wr(4'd4, (32'd1 << 24) | 32'd8);
    @(negedge clk);
    rd(4'd3, v); check("R10 all status", v, 0);
    rd(4'd5, v); check("R10 all reply", v, 0);
    rd(4'd0, v); check("R10 all arg", v, 0);
    rd(4'd4, v); check("R10 all limit default", v, 64);

    wr(4'd4, 32'd6);
    rd(4'd6, r1_keep);
    for (int it = 0; it < 60; it++) begin
      int idx, rt, d; bit ce, ie, ce_in, ie_in, dp; logic [31:0] a;
      idx = $urandom % 64; rt = $urandom % 4; ce = $urandom % 2; ie = $urandom % 2;
      dp = $urandom % 2; d = $urandom % 8; ce_in = $urandom % 2; ie_in = $urandom % 2;
      a = $urandom;
      wr(4'd0, a);
      wr(4'd2, mkcmd(idx, rt, ce, ie, dp));
      check("R1 rnd go", go, 1); check("R1 rnd index", go_index, 32'(idx));
      check("R1 rnd arg", go_arg, a); check("R1 rnd rtype", go_rtype, 32'(rt));
      if (rt == 0) begin
        check("R2 rnd done", ev_done, 1);
      end else begin
        for (int cyc = 1; ; cyc++) begin
          b = rnd120();
          if (cyc == d + 1) begin
            rsp_valid = 1'b1; rsp_bits = b; rsp_crc_err = ce_in; rsp_idx_err = ie_in;
          end
          @(negedge clk);
          if (rsp_valid) begin
            rsp_valid = 1'b0;
            check("R8 rnd reply wins", ev_timeout, 0);
            check("R7 rnd done", ev_done, 1);
            check("R7 rnd crc", ev_crc, 32'(ce && ce_in));
            check("R7 rnd index", ev_index, 32'(ie && ie_in));
            rd(4'd5, v); check("R5 rnd word0", v, b[31:0]);
            rd(4'd6, v);
            if (rt == 1) begin
              check("R5 rnd word1", v, b[63:32]); r1_keep = b[63:32];
              rd(4'd8, v); check("R5 rnd word3", v, {8'h0, b[119:96]});
            end else check("R6 rnd word1 kept", v, r1_keep);
            break;
          end else if (cyc == 6) begin
            check("R8 rnd timeout", ev_timeout, 1);
            break;
          end else begin
            check("R8 rnd waiting", ev_timeout, 0);
          end
        end
      end
      rd(4'd3, v); check("R9 rnd status", v, {30'h0, dp || rt == 3, 1'b0});
      @(negedge clk); dat_done = 1'b1; @(negedge clk); dat_done = 1'b0;
      rd(4'd3, v); check("R9 rnd cleared", v, 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule